// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. The converter starts a conversion when chip select falls. It keeps its data line released for four serial clock falling edges and drives a low marker bit at the fifth. It then shifts out the result MSB first, one bit per falling edge, and drives the line low again after the LSB. The controller lowers chip select, derives the serial clock from the system clock, checks the marker and any trailing bits, and assembles the 16-bit straight-binary word.

A conversion starts on a one-cycle `start` request or, with `auto_en` set, from an internal timer that paces conversions at a programmable period. Chip select is held high for a programmable minimum gap so that the converter can acquire. The period between two chip-select falls is never shorter than a floor that keeps throughput at or below 100 kHz. A request that cannot be served is dropped and reported on a one-cycle overrun strobe. The result appears on `data_out` with a one-cycle `data_valid` strobe and a `frame_err` flag, and both are held until the next result.

Top module: `adc_serial_reader`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1 and `sclk`, `data_valid`, `overrun`, `frame_err` and `data_out` are 0. After reset the first request is served at once.
- R2: A `start` seen at a clock edge where the controller is ready drives `cs_n` low from that edge. Ready means no frame is in progress, the gap of R7 has elapsed and the period of R8 has elapsed.
- R3: `sclk` is low while idle and is high only while `cs_n` is low. Its first rising edge comes H system cycles after `cs_n` falls, and it then toggles every H cycles. H is `half_div`, raised to 35 when smaller, which keeps the rate below 2.9 MHz at 200 MHz.
- R4: A frame has N serial clock cycles, where N is `sclk_cycles` limited to the range 22 to 24. `cs_n` rises on the edge that makes the Nth falling edge. `data_valid` is 1 for exactly that one cycle, after which `sclk` stays low.
- R5: The converter drives the marker after falling edge 5 and result bit 15-i after falling edge 6+i. When `cap_rise` is 1, each bit is sampled at the rising edge that follows it. When `cap_rise` is 0, it is sampled at the next falling edge. In both modes `data_out` equals the driven word, including 0x0000 and 0xFFFF.
- R6: `frame_err` is 1 with a result if the marker sample was 1, or if N is at least 23 and a sample taken after the LSB was 1. The word is delivered either way.
- R7: `cs_n` stays high for at least G cycles between frames, where G is `gap_cycles` raised to 80 (400 ns) when smaller.
- R8: Two falls of `cs_n` are at least P cycles apart, where P is `period_cycles` raised to 2000 (10 µs) when smaller. With `auto_en` set, a frame starts in every cycle in which the controller is ready, so frames repeat every P cycles when the frame and the gap fit.
- R9: A `start` at an edge where the controller is not ready is ignored, and `overrun` is 1 in the following cycle only.
- R10: `data_out` and `frame_err` change only in a cycle with `data_valid` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle conversion request |
| auto_en | input | 1 | Enables the internal pacing timer |
| cap_rise | input | 1 | 1: sample on rising edge, 0: on the next falling edge |
| half_div | input | 8 | System cycles per serial clock half period |
| sclk_cycles | input | 5 | Serial clock cycles per frame (limited to 22..24) |
| gap_cycles | input | 12 | Minimum chip-select high time in cycles |
| period_cycles | input | 20 | Conversion period in cycles |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select, starts the conversion |
| sclk | output | 1 | Serial clock to the converter |
| data_out | output | 16 | Last result word |
| data_valid | output | 1 | One-cycle strobe with a new result |
| frame_err | output | 1 | Marker or trailing-bit violation for the last result |
| overrun | output | 1 | One-cycle strobe for a dropped request |

## Verification
The critical overlap is a start request landing on the very edge that ends a frame, where the last falling edge, the release of chip select and the result strobe coincide. The bench raises `start` one cycle before the frame end predicted by its model. It expects `data_valid` and `overrun` together in the next cycle, `cs_n` high with the gap then counting, and the word intact. A manual request made while the pacing timer owns the link is the second overlap, and it is judged the same way against the model's prediction, cycle by cycle.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W     = 16,
  parameter int LEAD_FALLS = 5,
  parameter int EXTRA_MAX  = 2,
  parameter int CNT_W      = 5,
  parameter int DIV_W      = 8,
  parameter int MIN_HALF   = 35,
  parameter int GAP_W      = 12,
  parameter int MIN_GAP    = 80,
  parameter int PER_W      = 20,
  parameter int MIN_PERIOD = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              auto_en,
  input  logic              cap_rise,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CNT_W-1:0]  sclk_cycles,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic [PER_W-1:0]  period_cycles,
  input  logic              sdata_in,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid,
  output logic              frame_err,
  output logic              overrun
);
  localparam logic [CNT_W-1:0] MARK_N = CNT_W'(LEAD_FALLS + 1);
  localparam logic [CNT_W-1:0] LSB_N  = CNT_W'(LEAD_FALLS + 1 + DATA_W);
  localparam logic [CNT_W-1:0] N_HI   = CNT_W'(LEAD_FALLS + 1 + DATA_W + EXTRA_MAX);
  localparam logic [DIV_W-1:0] H_LO   = DIV_W'(MIN_HALF);
  localparam logic [GAP_W-1:0] G_LO   = GAP_W'(MIN_GAP);
  localparam logic [PER_W-1:0] P_LO   = PER_W'(MIN_PERIOD);

  logic              running, err_q, err_nx;
  logic [DIV_W-1:0]  div_q, half_eff;
  logic [CNT_W-1:0]  fall_q, ev_n, n_eff;
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [GAP_W-1:0]  gap_q, gap_eff;
  logic [PER_W-1:0]  since_q, per_eff;
  logic              ready, go, tick, samp, last;

  assign half_eff = (half_div < H_LO) ? H_LO : half_div;
  assign n_eff    = (sclk_cycles < LSB_N) ? LSB_N :
                    (sclk_cycles > N_HI) ? N_HI : sclk_cycles;
  assign gap_eff  = (gap_cycles < G_LO) ? G_LO : gap_cycles;
  assign per_eff  = (period_cycles < P_LO) ? P_LO : period_cycles;

  assign ready = !running && (gap_q >= gap_eff - GAP_W'(1))
                 && (since_q >= per_eff - PER_W'(1));
  assign go    = ready && (start || auto_en);
  assign tick  = running && (div_q == half_eff - DIV_W'(1));
  assign ev_n  = fall_q + CNT_W'(1);
  assign samp  = tick && (cap_rise ? !sclk : sclk);
  assign last  = tick && sclk && (ev_n == n_eff);

  always_comb begin
    sh_nx  = sh_q;
    err_nx = err_q;
    if (samp) begin
      if (ev_n == MARK_N)
        err_nx = err_q | sdata_in;
      else if (ev_n > MARK_N && ev_n <= LSB_N)
        sh_nx = {sh_q[DATA_W-2:0], sdata_in};
      else if (ev_n > LSB_N)
        err_nx = err_q | sdata_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cs_n       <= 1'b1;
      sclk       <= 1'b0;
      div_q      <= '0;
      fall_q     <= '0;
      sh_q       <= '0;
      err_q      <= 1'b0;
      gap_q      <= '1;
      since_q    <= '1;
      data_out   <= '0;
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      data_valid <= last;
      overrun    <= start && !go;
      since_q    <= go ? '0 : (&since_q ? since_q : since_q + PER_W'(1));
      gap_q      <= last ? '0 : (&gap_q ? gap_q : gap_q + GAP_W'(1));
      sh_q       <= go ? '0 : sh_nx;
      err_q      <= go ? 1'b0 : err_nx;
      if (go) begin
        running <= 1'b1;
        cs_n    <= 1'b0;
        div_q   <= '0;
        fall_q  <= '0;
      end else if (last) begin
        running   <= 1'b0;
        cs_n      <= 1'b1;
        sclk      <= 1'b0;
        data_out  <= sh_nx;
        frame_err <= err_nx;
      end else if (running) begin
        div_q <= tick ? '0 : div_q + DIV_W'(1);
        if (tick) sclk <= !sclk;
        if (tick && sclk) fall_q <= ev_n;
      end
    end
  end

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_valid_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (cs_n && $past(!cs_n)));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  assert_gap_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_q >= gap_eff));

  assert_period_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(since_q) >= $past(per_eff) - PER_W'(1)));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(start));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> ($stable(data_out) && $stable(frame_err)));
endmodule

// File: tb/sim_adc_serial_reader.sv
`timescale 1ns/1ps
module sim_adc_serial_reader;
  localparam int MH = 35, MG = 80, MP = 2000, NLO = 22, NHI = 24;
  localparam int BIG = 1 << 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_r = 1'b0, auto_r = 1'b0, mode_r = 1'b0;
  logic [7:0]  half_r = 8'd35;
  logic [4:0]  cyc_r = 5'd24;
  logic [11:0] gap_r = 12'd0;
  logic [19:0] per_r = 20'd0;
  logic        sdata_r = 1'b1;
  logic        cs_n, sclk, data_valid, frame_err, overrun;
  logic [15:0] data_out;

  always #2.5 clk = ~clk;

  adc_serial_reader u0 (
    .clk(clk), .rst_n(rst_n), .start(start_r), .auto_en(auto_r), .cap_rise(mode_r),
    .half_div(half_r), .sclk_cycles(cyc_r), .gap_cycles(gap_r), .period_cycles(per_r),
    .sdata_in(sdata_r), .cs_n(cs_n), .sclk(sclk), .data_out(data_out),
    .data_valid(data_valid), .frame_err(frame_err), .overrun(overrun));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // converter model
  logic [15:0] adc_word = 16'h0;
  bit adc_bad_mark = 0, adc_bad_trail = 0;
  int fcnt = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (cs_n) begin
      fcnt = 0;
      sdata_r = 1'b1;
    end else if (prev_sclk && !sclk) begin
      fcnt++;
      if (fcnt < 5)       sdata_r = 1'b1;
      else if (fcnt == 5) sdata_r = adc_bad_mark;
      else if (fcnt <= 21) sdata_r = adc_word[21-fcnt];
      else                sdata_r = adc_bad_trail;
    end
    prev_sclk = sclk;
  end

  // behavioural reference
  bit m_cs, m_sclk, m_valid, m_ovr, m_err, m_run, m_rdy, m_bad, rdy, go;
  int m_data, m_t, m_since, m_gap, m_h, m_n, m_word, eg, ep;

  function automatic int eff_h(int v); return (v < MH) ? MH : v; endfunction
  function automatic int eff_n(int v); return (v < NLO) ? NLO : (v > NHI) ? NHI : v; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 1; m_sclk = 0; m_valid = 0; m_ovr = 0; m_data = 0; m_err = 0;
      m_run = 0; m_t = 0; m_since = BIG; m_gap = BIG; m_rdy = 1;
    end else begin
      eg = (gap_r < MG) ? MG : int'(gap_r);
      ep = (per_r < MP) ? MP : int'(per_r);
      rdy = !m_run && m_gap >= eg - 1 && m_since >= ep - 1;
      go = rdy && (start_r || auto_r);
      m_ovr = start_r && !go;
      m_valid = 0;
      if (m_since < BIG) m_since++;
      if (m_gap < BIG) m_gap++;
      if (go) begin
        m_run = 1; m_t = 0; m_cs = 0; m_sclk = 0; m_since = 0;
        m_h = eff_h(half_r); m_n = eff_n(cyc_r); m_word = adc_word;
        m_bad = adc_bad_mark || (adc_bad_trail && m_n > NLO);
      end else if (m_run) begin
        m_t++;
        if (m_t == 2 * m_n * m_h) begin
          m_run = 0; m_cs = 1; m_sclk = 0; m_valid = 1;
          m_data = m_word; m_err = m_bad; m_gap = 0;
        end else begin
          m_sclk = ((m_t / m_h) % 2) == 1;
        end
      end
      m_rdy = !m_run && m_gap >= eg - 1 && m_since >= ep - 1;
    end
  end

  task automatic chk(string tag, string name, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "data_valid", data_valid, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "data_out", data_out, 0);
      end else begin
        chk("R2 R7 R8", "cs_n", cs_n, m_cs);
        chk("R3", "sclk", sclk, m_sclk);
        chk("R4", "data_valid", data_valid, m_valid);
        chk(m_valid ? "R5" : "R10", "data_out", data_out, m_data);
        chk(m_valid ? "R6" : "R10", "frame_err", frame_err, m_err);
        chk("R9", "overrun", overrun, m_ovr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=done at %0t", $time);
      finish_run();
    end
  end

  task automatic pulse_start();
    start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
  endtask

  task automatic wait_ready();
    while (!m_rdy) @(negedge clk);
  endtask

  task automatic wait_result();
    while (!m_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic conv(input logic [15:0] w, input bit md, input int cnt, input int h,
                      input bit bm, input bit bt);
    wait_ready();
    adc_word = w; adc_bad_mark = bm; adc_bad_trail = bt;
    mode_r = md; cyc_r = 5'(cnt); half_r = 8'(h);
    pulse_start();
    wait_result();
  endtask

  initial begin
    repeat (5) @(negedge clk);          // R1 reset values checked here
    rst_n = 1'b1;
    @(negedge clk);
    conv(16'hA5C3, 0, 24, 35, 0, 0);    // R2 R3 R4 R5 falling capture
    conv(16'h1234, 1, 22, 40, 0, 0);    // R5 rising capture, 22 cycles
    conv(16'hFFFF, 1, 30, 3, 0, 0);     // R3 R4 limits, over-range code
    conv(16'h0000, 0, 5, 50, 0, 0);     // R4 lower limit, under-range code
    conv(16'h8001, 0, 24, 35, 1, 0);    // R6 bad marker
    conv(16'h7FFF, 1, 23, 35, 0, 1);    // R6 trailing bit sampled
    conv(16'h0001, 0, 22, 35, 0, 1);    // R6 no trailing sample at 22
    // R9 request during frame and during gap
    wait_ready();
    adc_word = 16'h5A5A; adc_bad_mark = 0; adc_bad_trail = 0; cyc_r = 5'd24; half_r = 8'd35;
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_result();
    pulse_start();
    // R9 request on the frame-ending edge
    wait_ready();
    adc_word = 16'hC001; mode_r = 1; cyc_r = 5'd22;
    pulse_start();
    while (!(m_run && m_t == 2 * m_n * m_h - 1)) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    // R7 long gap binds, then R8 period binds
    gap_r = 12'd700;
    conv(16'h2468, 0, 22, 35, 0, 0);
    conv(16'h1357, 1, 22, 35, 0, 0);
    gap_r = 12'd10;
    per_r = 20'd3000;
    conv(16'h0F0F, 0, 22, 35, 0, 0);
    conv(16'hF0F0, 1, 24, 35, 0, 0);
    // R8 timer pacing, with a manual request mixed in (R9)
    wait_ready();
    per_r = 20'd2500; gap_r = 12'd0; adc_word = 16'h6B3D; mode_r = 0; cyc_r = 5'd24;
    auto_r = 1'b1;
    repeat (4000) @(negedge clk);
    pulse_start();
    repeat (5000) @(negedge clk);
    auto_r = 1'b0;
    wait_ready();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule